// File: doc/BRIEF.md
# Battery Monitor Power Mode Controller

This block sequences a battery monitor through its power modes: NORMAL, SLEEP, DEEPSLEEP, a terminal SHUTDOWN, and a low-power wait state that is left on a rising edge of the LD pin. A 16-bit power configuration word decides several behaviours. It controls whether overtemperature forces shutdown and whether overtemperature is watched while in deep sleep. It decides whether an LD rising edge wakes the block from deep sleep, and whether a shutdown request is replaced by the LD wait state. It also sets which of the regulator and the low-frequency oscillator stay powered in deep sleep.

Host commands arrive as one-cycle strobes. They request deep sleep entry or exit, request shutdown, and set or clear the sleep-enable status bit. The LD pin is asynchronous, so it is synchronised internally and turned into a one-cycle edge pulse. All outputs are registered and change on the same clock edge. The block has no data stream, so every pin is a plain control or status signal with no handshake or back-pressure. Reset is synchronous and active high.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While rst is high at a clock edge, mode becomes NORMAL (code 0), reg_en and lfo_en become 1, and sleep_en takes the value of cfg_word bit 8.
- R2: Outside reset, cmd_sleep_on sets sleep_en at the next edge and cmd_sleep_off clears it. If both are high in the same cycle, sleep_en is cleared.
- R3: NORMAL moves to SLEEP (code 1) when sleep_en and sleep_cond are both 1. SLEEP returns to NORMAL when either of them is 0.
- R4: cmd_ds_enter moves NORMAL or SLEEP to DEEPSLEEP (code 2). cmd_ds_exit moves DEEPSLEEP to NORMAL.
- R5: A rising edge on ld_pin passes through a two-flop synchroniser and an edge register. If ld_pin goes high before clock edge k, the wake acts at edge k+2. In DEEPSLEEP the edge returns the block to NORMAL only when cfg_word bit 11 is 1; otherwise it is ignored.
- R6: In NORMAL or SLEEP, ot_flag high enters the shutdown target when cfg_word bit 7 is 1. When bit 7 is 0, ot_flag has no effect in these modes.
- R7: In DEEPSLEEP, ot_flag high enters the shutdown target when cfg_word bit 13 is 1. When bit 13 is 0, ot_flag is ignored in DEEPSLEEP.
- R8: cmd_shutdown moves NORMAL, SLEEP or DEEPSLEEP to the shutdown target.
- R9: The shutdown target is SHUTDOWN (code 3) when cfg_word bit 12 is 0 and LD-wait (code 4) when it is 1. LD-wait returns to NORMAL on a synchronised LD rising edge, whatever the value of bit 11.
- R10: SHUTDOWN ignores every input except rst.
- R11: reg_en and lfo_en are 1 in NORMAL and SLEEP and 0 in SHUTDOWN and LD-wait. In DEEPSLEEP, lfo_en equals cfg_word bit 9. On entry to DEEPSLEEP, reg_en keeps its value when cfg_word bit 10 is 1 and is cleared when bit 10 is 0; it then holds for the rest of the stay.
- R12: Within one cycle the causes rank as follows: enabled overtemperature first, then cmd_shutdown, then the deep-sleep exit or LD wake, then cmd_ds_enter, then the sleep condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 16 | Power configuration word (default 0x2982) |
| cmd_ds_enter | input | 1 | Host strobe: enter deep sleep |
| cmd_ds_exit | input | 1 | Host strobe: leave deep sleep |
| cmd_shutdown | input | 1 | Host strobe: shut down |
| cmd_sleep_on | input | 1 | Host strobe: set sleep_en |
| cmd_sleep_off | input | 1 | Host strobe: clear sleep_en |
| ld_pin | input | 1 | Asynchronous LD pin level |
| ot_flag | input | 1 | On-chip overtemperature flag |
| sleep_cond | input | 1 | Sleep condition met |
| mode | output | 3 | Current mode code |
| sleep_en | output | 1 | Sleep-enable status bit |
| reg_en | output | 1 | Regulator enable |
| lfo_en | output | 1 | Low-frequency oscillator enable |

## Verification
The assertions assume three things about the inputs. Reset is high from time zero until the first clock edge. Every input carries a known level at each edge. Strobes and flags may overlap freely. The stimulus respects this by driving every input from a defined value on the falling edge. It changes cfg_word only while reset is held, so a mid-stay reconfiguration is never mistaken for a transition. Commands, overtemperature and LD toggles are drawn sparsely enough that each mode is occupied for many cycles between events.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_SLEEP  = 3'd1,
    PM_DEEP   = 3'd2,
    PM_OFF    = 3'd3,
    PM_LDWAIT = 3'd4
  } pm_mode_t;

  // configuration bit positions
  localparam int unsigned BIT_OT_OFF      = 7;
  localparam int unsigned BIT_SLEEP_DEF   = 8;
  localparam int unsigned BIT_DS_KEEP_LFO = 9;
  localparam int unsigned BIT_DS_KEEP_REG = 10;
  localparam int unsigned BIT_DS_LD_WAKE  = 11;
  localparam int unsigned BIT_OFF_TO_WAIT = 12;
  localparam int unsigned BIT_DS_OT       = 13;

  localparam logic [15:0] CFG_DEFAULT = 16'h2982;

  typedef struct packed {
    logic ds_ot;        // overtemperature watched in deep sleep
    logic off_to_wait;  // shutdown replaced by LD wait
    logic ds_ld_wake;   // LD edge leaves deep sleep
    logic ds_keep_reg;  // regulator left as is in deep sleep
    logic ds_keep_lfo;  // oscillator kept running in deep sleep
    logic sleep_def;    // reset value of sleep enable
    logic ot_off;       // overtemperature forces shutdown when active
  } pm_cfg_t;

endpackage

// File: rtl/ld_edge_detect.sv
module ld_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b0;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sleep_en_reg.sv
module sleep_en_reg (
  input  logic clk,
  input  logic rst,
  input  logic def_val,
  input  logic set_i,
  input  logic clr_i,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst)        en_q <= def_val;
    else if (clr_i) en_q <= 1'b0;
    else if (set_i) en_q <= 1'b1;
  end
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pwrmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_cfg_t  cfg,
  input  logic     sleep_en,
  input  logic     sleep_cond,
  input  logic     ot,
  input  logic     cmd_off,
  input  logic     cmd_ds_in,
  input  logic     cmd_ds_out,
  input  logic     ld_rise,
  output pm_mode_t mode_q,
  output pm_mode_t mode_d
);
  pm_mode_t off_tgt;
  logic     may_sleep;

  assign off_tgt   = cfg.off_to_wait ? PM_LDWAIT : PM_OFF;
  assign may_sleep = sleep_en & sleep_cond;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_NORMAL, PM_SLEEP: begin
        if (ot && cfg.ot_off) mode_d = off_tgt;
        else if (cmd_off)     mode_d = off_tgt;
        else if (cmd_ds_in)   mode_d = PM_DEEP;
        else if (may_sleep)   mode_d = PM_SLEEP;
        else                  mode_d = PM_NORMAL;
      end
      PM_DEEP: begin
        if (ot && cfg.ds_ot)                           mode_d = off_tgt;
        else if (cmd_off)                              mode_d = off_tgt;
        else if (cmd_ds_out || (ld_rise && cfg.ds_ld_wake)) mode_d = PM_NORMAL;
        else                                           mode_d = PM_DEEP;
      end
      PM_OFF:    mode_d = PM_OFF;
      PM_LDWAIT: mode_d = ld_rise ? PM_NORMAL : PM_LDWAIT;
      default:   mode_d = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PM_NORMAL;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/pm_power_out.sv
module pm_power_out
  import pwrmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_cfg_t  cfg,
  input  pm_mode_t mode_q,
  input  pm_mode_t mode_d,
  output logic     reg_en_q,
  output logic     lfo_en_q
);
  logic reg_d, lfo_d;

  always_comb begin
    unique case (mode_d)
      PM_NORMAL, PM_SLEEP: begin
        reg_d = 1'b1;
        lfo_d = 1'b1;
      end
      PM_DEEP: begin
        lfo_d = cfg.ds_keep_lfo;
        if (mode_q == PM_DEEP) reg_d = reg_en_q;
        else                   reg_d = reg_en_q & cfg.ds_keep_reg;
      end
      default: begin
        reg_d = 1'b0;
        lfo_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_en_q <= 1'b1;
      lfo_en_q <= 1'b1;
    end else begin
      reg_en_q <= reg_d;
      lfo_en_q <= lfo_d;
    end
  end
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int unsigned CFG_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cmd_ds_enter,
  input  logic             cmd_ds_exit,
  input  logic             cmd_shutdown,
  input  logic             cmd_sleep_on,
  input  logic             cmd_sleep_off,
  input  logic             ld_pin,
  input  logic             ot_flag,
  input  logic             sleep_cond,
  output logic [2:0]       mode,
  output logic             sleep_en,
  output logic             reg_en,
  output logic             lfo_en
);
  pm_cfg_t  cfg;
  pm_mode_t st_q, st_d;
  logic     ld_rise;

  assign cfg.ds_ot       = cfg_word[BIT_DS_OT];
  assign cfg.off_to_wait = cfg_word[BIT_OFF_TO_WAIT];
  assign cfg.ds_ld_wake  = cfg_word[BIT_DS_LD_WAKE];
  assign cfg.ds_keep_reg = cfg_word[BIT_DS_KEEP_REG];
  assign cfg.ds_keep_lfo = cfg_word[BIT_DS_KEEP_LFO];
  assign cfg.sleep_def   = cfg_word[BIT_SLEEP_DEF];
  assign cfg.ot_off      = cfg_word[BIT_OT_OFF];

  ld_edge_detect #(.STAGES(SYNC_STAGES)) u_ld (
    .clk (clk),
    .rst (rst),
    .pin (ld_pin),
    .rise(ld_rise)
  );

  sleep_en_reg u_sen (
    .clk    (clk),
    .rst    (rst),
    .def_val(cfg.sleep_def),
    .set_i  (cmd_sleep_on),
    .clr_i  (cmd_sleep_off),
    .en_q   (sleep_en)
  );

  pm_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .sleep_en  (sleep_en),
    .sleep_cond(sleep_cond),
    .ot        (ot_flag),
    .cmd_off   (cmd_shutdown),
    .cmd_ds_in (cmd_ds_enter),
    .cmd_ds_out(cmd_ds_exit),
    .ld_rise   (ld_rise),
    .mode_q    (st_q),
    .mode_d    (st_d)
  );

  pm_power_out u_pwr (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .mode_q  (st_q),
    .mode_d  (st_d),
    .reg_en_q(reg_en),
    .lfo_en_q(lfo_en)
  );

  assign mode = st_q;
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk #(
  parameter int unsigned CFG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_word,
  input logic             cmd_ds_exit,
  input logic             cmd_shutdown,
  input logic             cmd_sleep_on,
  input logic             cmd_sleep_off,
  input logic             ot_flag,
  input logic             sleep_cond,
  input logic [2:0]       mode,
  input logic             sleep_en,
  input logic             reg_en,
  input logic             lfo_en
);
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd3 |=> mode == 3'd3); // R10

  AST_LOWPWR_RAILS_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 || mode == 3'd4) |-> (!reg_en && !lfo_en)); // R11

  AST_ACTIVE_RAILS_ON: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode == 3'd1) |-> (reg_en && lfo_en)); // R11

  AST_NO_SLEEP_WITHOUT_EN: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && !(sleep_en && sleep_cond)) |=> mode != 3'd1); // R3

  AST_WAIT_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd4 && !cfg_word[12]) |=> mode != 3'd4); // R9

  AST_DS_LD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && !cmd_ds_exit && !cmd_shutdown && !cfg_word[11]
     && !(ot_flag && cfg_word[13])) |=> mode == 3'd2); // R5

  AST_SLEEP_SET: assert property (@(posedge clk) disable iff (rst)
    (cmd_sleep_on && !cmd_sleep_off) |=> sleep_en); // R2

  AST_SLEEP_CLR: assert property (@(posedge clk) disable iff (rst)
    cmd_sleep_off |=> !sleep_en); // R2

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4); // R12
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_word     (cfg_word),
  .cmd_ds_exit  (cmd_ds_exit),
  .cmd_shutdown (cmd_shutdown),
  .cmd_sleep_on (cmd_sleep_on),
  .cmd_sleep_off(cmd_sleep_off),
  .ot_flag      (ot_flag),
  .sleep_cond   (sleep_cond),
  .mode         (mode),
  .sleep_en     (sleep_en),
  .reg_en       (reg_en),
  .lfo_en       (lfo_en)
);

// File: tb/sim_pwrmode_ctrl.sv
`timescale 1ns/1ps
module sim_pwrmode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_word = 16'h2982;
  logic cmd_ds_enter = 0, cmd_ds_exit = 0, cmd_shutdown = 0;
  logic cmd_sleep_on = 0, cmd_sleep_off = 0;
  logic ld_pin = 0, ot_flag = 0, sleep_cond = 0;
  logic [2:0] mode;
  logic sleep_en, reg_en, lfo_en;

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;

  always #2 clk = ~clk;

  pwrmode_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word),
    .cmd_ds_enter(cmd_ds_enter), .cmd_ds_exit(cmd_ds_exit),
    .cmd_shutdown(cmd_shutdown), .cmd_sleep_on(cmd_sleep_on),
    .cmd_sleep_off(cmd_sleep_off), .ld_pin(ld_pin), .ot_flag(ot_flag),
    .sleep_cond(sleep_cond), .mode(mode), .sleep_en(sleep_en),
    .reg_en(reg_en), .lfo_en(lfo_en)
  );

  // ---------------- reference model built from the requirements
  logic [2:0] m_mode;
  logic       m_sen, m_reg, m_lfo, m_s0, m_s1, m_prev;

  function automatic logic [2:0] f_next(input logic [2:0] m, input logic [15:0] c,
      input logic se, input logic sc, input logic ot, input logic sh,
      input logic dsi, input logic dso, input logic edg);
    logic [2:0] tgt;
    tgt = c[12] ? 3'd4 : 3'd3;  // R9
    case (m)
      3'd0, 3'd1: begin
        if (ot && c[7])     return tgt;   // R6
        if (sh)             return tgt;   // R8
        if (dsi)            return 3'd2;  // R4
        return (se && sc) ? 3'd1 : 3'd0;  // R3
      end
      3'd2: begin
        if (ot && c[13])            return tgt;  // R7
        if (sh)                     return tgt;
        if (dso || (edg && c[11]))  return 3'd0; // R4 R5
        return 3'd2;
      end
      3'd3: return 3'd3;                  // R10
      3'd4: return edg ? 3'd0 : 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic f_reg(input logic [2:0] cur, input logic [2:0] nxt,
      input logic [15:0] c, input logic r);
    if (nxt <= 3'd1) return 1'b1;
    if (nxt == 3'd2) return (cur == 3'd2) ? r : (r & c[10]);
    return 1'b0;
  endfunction

  function automatic logic f_lfo(input logic [2:0] nxt, input logic [15:0] c);
    if (nxt <= 3'd1) return 1'b1;
    if (nxt == 3'd2) return c[9];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic [2:0] nx;
    started <= 1'b1;
    if (rst) begin
      m_mode <= 3'd0; m_sen <= cfg_word[8]; m_reg <= 1'b1; m_lfo <= 1'b1;
      m_s0 <= 1'b0; m_s1 <= 1'b0; m_prev <= 1'b0;
    end else begin
      nx = f_next(m_mode, cfg_word, m_sen, sleep_cond, ot_flag, cmd_shutdown,
                  cmd_ds_enter, cmd_ds_exit, m_s1 & ~m_prev);
      m_mode <= nx;
      m_reg  <= f_reg(m_mode, nx, cfg_word, m_reg);
      m_lfo  <= f_lfo(nx, cfg_word);
      if (cmd_sleep_off)     m_sen <= 1'b0;
      else if (cmd_sleep_on) m_sen <= 1'b1;
      m_s0 <= ld_pin; m_s1 <= m_s0; m_prev <= m_s1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk("R3/R4/R5/R6/R7/R8/R9/R10/R12 mode", mode, m_mode);
      chk("R2 sleep_en", sleep_en, m_sen);
      chk("R11 reg_en", reg_en, m_reg);
      chk("R11 lfo_en", lfo_en, m_lfo);
    end
  end

  task automatic do_reset(input logic [15:0] c);
    @(negedge clk);
    rst = 1'b1; cfg_word = c;
    {cmd_ds_enter, cmd_ds_exit, cmd_shutdown, cmd_sleep_on, cmd_sleep_off} = '0;
    ld_pin = 0; ot_flag = 0; sleep_cond = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: cmd_ds_enter = 1;
      1: cmd_ds_exit = 1;
      2: cmd_shutdown = 1;
      3: cmd_sleep_on = 1;
      default: cmd_sleep_off = 1;
    endcase
    @(negedge clk);
    {cmd_ds_enter, cmd_ds_exit, cmd_shutdown, cmd_sleep_on, cmd_sleep_off} = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DE5_0A7B));
    // R1 reset state with default word
    do_reset(16'h2982);
    chk("R1 mode", mode, 0); chk("R1 sleep_en", sleep_en, 1);
    chk("R1 reg_en", reg_en, 1); chk("R1 lfo_en", lfo_en, 1);
    // R1 sleep default follows bit 8
    do_reset(16'h2882);
    chk("R1 sleep_en clear", sleep_en, 0);
    // R2 simultaneous set and clear
    strobe(3); chk("R2 set", sleep_en, 1);
    @(negedge clk); cmd_sleep_on = 1; cmd_sleep_off = 1;
    @(negedge clk); cmd_sleep_on = 0; cmd_sleep_off = 0;
    chk("R2 both clear", sleep_en, 0);
    // R6 overtemperature ignored when bit 7 clear
    do_reset(16'h2902);
    @(negedge clk); ot_flag = 1; repeat (3) @(negedge clk); ot_flag = 0;
    chk("R6 ot ignored", mode, 0);
    // R5 latency of LD wake, R11 rails in deep sleep
    do_reset(16'h2982);
    strobe(0);
    chk("R4 deep", mode, 2); chk("R11 reg off", reg_en, 0); chk("R11 lfo off", lfo_en, 0);
    ld_pin = 1;
    @(negedge clk); chk("R5 wait1", mode, 2);
    @(negedge clk); chk("R5 wait2", mode, 2);
    @(negedge clk); chk("R5 woke", mode, 0);
    ld_pin = 0;
    // R9 LD-wait replaces shutdown
    do_reset(16'h3982);
    strobe(2); chk("R9 ldwait", mode, 4);
    ld_pin = 1; repeat (3) @(negedge clk); chk("R9 wake", mode, 0); ld_pin = 0;
    // R10 shutdown is terminal
    do_reset(16'h2982);
    strobe(2); chk("R10 off", mode, 3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ld_pin = i[0]; cmd_ds_exit = 1; cmd_sleep_on = 1; ot_flag = 1; sleep_cond = 1;
    end
    @(negedge clk);
    {cmd_ds_exit, cmd_sleep_on, ot_flag, sleep_cond, ld_pin} = '0;
    chk("R10 still off", mode, 3);

    // random phases
    for (int seg = 0; seg < 40; seg++) begin
      do_reset(16'($urandom()) | (seg < 4 ? 16'h0 : 16'h0));
      for (int cyc = 0; cyc < 200; cyc++) begin
        @(negedge clk);
        cmd_ds_enter  = ($urandom_range(15) == 0);
        cmd_ds_exit   = ($urandom_range(15) == 0);
        cmd_shutdown  = ($urandom_range(90) == 0);
        cmd_sleep_on  = ($urandom_range(12) == 0);
        cmd_sleep_off = ($urandom_range(20) == 0);
        ot_flag       = ($urandom_range(60) == 0);
        if ($urandom_range(5) == 0) ld_pin = ~ld_pin;
        if ($urandom_range(9) == 0) sleep_cond = ~sleep_cond;
      end
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule